// File: doc/BRIEF.md
# Reversible 4-bit Counter with Terminal-Count and Gated Ripple Output

This block is a four-bit binary counter that can step in either direction. It also has a level-sensitive preset. The counting clock `cp` is not used as a clock. It is sampled in the fast system clock domain `clk`, passed through a two-stage synchronizer, and its rising edges are found by comparing the synchronized level with its value one cycle earlier. Each detected rising edge moves the count one step, provided the active-low enable `cen_n` is low.

While the active-low preset `load_n` is held low, the data inputs appear on the count outputs in the same cycle and are written into the count register. The preset takes priority over counting. Two outputs support cascading. `tc` flags the end of the count range for the selected direction. `rc_n` is an active-low pulse that follows the low phase of the synchronized `cp`, but only while `tc` is high and the enable is asserted.

Top module: `udc_counter4`

## Requirements
- R1: A synchronous active-high `rst` clears the count to 0.
- R2: While `load_n` is 0, `q` equals `data_in` in the same cycle, and the count register takes `data_in`. No counting happens while the preset is held, whatever `cen_n` or `cp` do.
- R3: With `load_n` = 1 and `cen_n` = 0, each rising edge of `cp` moves the count by exactly one. The new value shows on `q` no later than three `clk` cycles after that edge.
- R4: While `cen_n` is 1, rising edges of `cp` leave the count unchanged.
- R5: `dir` = 0 counts up and `dir` = 1 counts down. Counting wraps modulo 16, so 15 goes to 0 when counting up and 0 goes to 15 when counting down.
- R6: `tc` is 1 exactly when `dir` = 0 and `q` = 15, or when `dir` = 1 and `q` = 0. A change of `dir` or of `q` updates it in the same cycle.
- R7: `tc` does not depend on `cen_n`.
- R8: `rc_n` is 0 only when `tc` = 1, `cen_n` = 0 and the synchronized `cp` level is 0. In every other case it is 1.
- R9: Each rising edge of `cp` produces a step request that lasts exactly one `clk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cp | input | 1 | Counting clock, sampled as data |
| load_n | input | 1 | Active-low level preset |
| data_in | input | 4 | Preset value |
| cen_n | input | 1 | Active-low count enable |
| dir | input | 1 | Direction: 0 up, 1 down |
| q | output | 4 | Count value |
| tc | output | 1 | Terminal-count flag |
| rc_n | output | 1 | Active-low gated ripple clock |

## Verification
The assertions check the following on every cycle:
- the one-cycle width of each step request;
- the hold of the count while disabled;
- the write of the preset value;
- the exact increment or decrement, including wraparound;
- the rule that `rc_n` stays high when `tc` is low or the enable is off.

Some behaviour only the bench scenarios can show:
- the combinational pass-through of `data_in` during a preset;
- the immediate response of `tc` to a direction change while the count sits at 0 or 15;
- the independence of `tc` from `cen_n`;
- the pulse of `rc_n` during the low phase of `cp` at the range ends.

These are checked against a bench reference model after each `cp` phase.

// File: rtl/udc_pkg.sv
package udc_pkg;
    localparam int CNT_W   = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
    } core_state_t;
endpackage

// File: rtl/udc_edge_sync.sv
module udc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cp,
    output logic cp_lvl,
    output logic step
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } es_state_t;

    es_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], cp};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cp_lvl = st_q.sync[STAGES-1];
    assign step   = st_q.sync[STAGES-1] & ~st_q.prev;

    // R9: a step request never lasts more than one cycle
    a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
    import udc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic load_n,
    input  cnt_t data_in,
    input  logic cen_n,
    input  logic dir,
    output cnt_t cnt
);
    core_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            st_d.cnt = data_in;
        end else if (step && !cen_n) begin
            if (dir) st_d.cnt = st_q.cnt - cnt_t'(1);
            else     st_d.cnt = st_q.cnt + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R2: the preset value is captured
    a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> st_q.cnt == $past(data_in));
    // R4: disabled counter holds
    a_r4_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (load_n && cen_n) |=> $stable(st_q.cnt));
    // R3 / R5: one step up with wrap
    a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cen_n && step && !dir) |=> st_q.cnt == cnt_t'($past(st_q.cnt) + 1'b1));
    // R3 / R5: one step down with wrap
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cen_n && step && dir) |=> st_q.cnt == cnt_t'($past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/udc_term_decode.sv
module udc_term_decode
    import udc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t q,
    input  logic dir,
    input  logic cen_n,
    input  logic cp_lvl,
    output logic tc,
    output logic rc_n
);
    logic at_top, at_bottom;

    assign at_top    = (q == cnt_t'(CNT_MAX));
    assign at_bottom = (q == '0);
    assign tc        = dir ? at_bottom : at_top;
    assign rc_n      = ~(tc & ~cen_n & ~cp_lvl);

    // R8: ripple output idles when the flag is low
    a_r8_rc_idle: assert property (@(posedge clk) disable iff (rst)
        !tc |-> rc_n);
    // R8: disabled enable blocks any ripple pulse
    a_r8_rc_blocked: assert property (@(posedge clk) disable iff (rst)
        cen_n |-> rc_n);
endmodule

// File: rtl/udc_counter4.sv
module udc_counter4
    import udc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cp,
    input  logic             load_n,
    input  logic [CNT_W-1:0] data_in,
    input  logic             cen_n,
    input  logic             dir,
    output logic [CNT_W-1:0] q,
    output logic             tc,
    output logic             rc_n
);
    logic cp_lvl, step;
    cnt_t cnt;

    udc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .cp(cp), .cp_lvl(cp_lvl), .step(step)
    );

    udc_count_core u_core (
        .clk(clk), .rst(rst), .step(step), .load_n(load_n),
        .data_in(data_in), .cen_n(cen_n), .dir(dir), .cnt(cnt)
    );

    // Preset passes straight through while held
    assign q = load_n ? cnt : data_in;

    udc_term_decode u_dec (
        .clk(clk), .rst(rst), .q(q), .dir(dir), .cen_n(cen_n),
        .cp_lvl(cp_lvl), .tc(tc), .rc_n(rc_n)
    );
endmodule

// File: tb/udc_counter4_tb.sv
`timescale 1ns/1ps
module udc_counter4_tb;
    logic       clk = 0, rst = 1, cp = 0, load_n = 1, cen_n = 0, dir = 0;
    logic [3:0] data_in = 0;
    logic [3:0] q;
    logic       tc, rc_n;
    logic [3:0] model = 0;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    udc_counter4 u_dut (.clk(clk), .rst(rst), .cp(cp), .load_n(load_n),
        .data_in(data_in), .cen_n(cen_n), .dir(dir), .q(q), .tc(tc), .rc_n(rc_n));

    function automatic logic exp_tc(logic [3:0] m, logic d);
        return d ? (m == 4'd0) : (m == 4'd15);
    endfunction

    function automatic logic exp_rc(logic [3:0] m, logic d, logic en_n, logic c);
        return ~(exp_tc(m, d) & ~en_n & ~c);
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " q"}, q, model);
        check({tag, " tc R6"}, {3'b0, tc}, {3'b0, exp_tc(model, dir)});
        check({tag, " rc_n R8"}, {3'b0, rc_n}, {3'b0, exp_rc(model, dir, cen_n, cp)});
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    // one full cp pulse; model updates on the rising edge
    task automatic cp_pulse(string tag);
        @(negedge clk); cp = 0;
        wait_cyc(6);
        check_all({tag, " low"});
        @(negedge clk); cp = 1;
        if (load_n && !cen_n) model = dir ? model - 4'd1 : model + 4'd1;
        wait_cyc(6);
        check_all({tag, " high"});
        @(negedge clk); cp = 0;
        wait_cyc(6);
    endtask

    task automatic do_load(logic [3:0] v);
        @(negedge clk); data_in = v; load_n = 0;
        #0.5;
        check("R2 passthrough", q, v);
        model = v;
        @(negedge clk); cp = 1;
        wait_cyc(6);
        check("R2 no count during load", q, v);
        @(negedge clk); cp = 0;
        wait_cyc(6);
        @(negedge clk); load_n = 1; data_in = ~v;
        wait_cyc(2);
        check("R2 held after load", q, v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0191));
        wait_cyc(3);
        @(negedge clk); rst = 0;
        wait_cyc(1);
        check("R1 reset count", q, 4'd0);
        check("R6 tc up at 0", {3'b0, tc}, 4'd0);
        @(negedge clk); dir = 1; #0.5;
        check("R6 tc down at 0", {3'b0, tc}, 4'd1);
        check("R8 rc low at 0 down", {3'b0, rc_n}, 4'd0);
        @(negedge clk); cen_n = 1; #0.5;
        check("R7 tc ignores cen_n", {3'b0, tc}, 4'd1);
        check("R8 rc blocked", {3'b0, rc_n}, 4'd1);
        @(negedge clk); cen_n = 0;
        cp_pulse("R5 wrap down 0->15");
        check("R5 wrapped to 15", q, 4'd15);
        @(negedge clk); dir = 0; #0.5;
        check("R6 tc after dir flip at 15", {3'b0, tc}, 4'd1);
        cp_pulse("R5 wrap up 15->0");
        check("R5 wrapped to 0", q, 4'd0);
        @(negedge clk); cen_n = 1;
        cp_pulse("R4 hold");
        check("R4 held at 0", q, 4'd0);
        @(negedge clk); cen_n = 0;
        do_load(4'd15);
        check_all("R2 load 15");
        @(negedge clk); dir = 1; #0.5;
        check_all("R6 dir down at 15");
        do_load(4'd9);
        cp_pulse("R3 count down");
        check("R3 9 to 8", q, 4'd8);

        for (int i = 0; i < 250; i++) begin
            @(negedge clk);
            dir   = 1'($urandom_range(0, 1));
            cen_n = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) begin
                logic [3:0] v;
                v = ($urandom_range(0, 1) == 1) ? 4'd15 : 4'($urandom_range(0, 15));
                if ($urandom_range(0, 3) == 0) v = 4'd0;
                do_load(v);
            end
            cp_pulse("R3 random");
        end
        finish_run();
    end
endmodule